// File: doc/BRIEF.md
# JTAG Shift Macro TDO Sequencer

This block drives the TMS and TDO lines of a JTAG master while a shift macro runs. A macro carries a nine-bit TMS pattern, indexed 0 to 8. Once started, the block first walks TMS through pattern bits 0 to 7 on eight consecutive TCK falling edges. It then serializes a test vector onto TDO, one bit per falling edge, with TMS held at pattern bit 7. On the edge that carries the final vector bit, TMS takes pattern bit 8. The vector arrives as words on a ready/valid stream and is sent least-significant bit first.

The block does not generate TCK. It runs on the system clock and receives a one-cycle strobe `tck_fall` that marks each TCK falling edge. Every change on TMS, TDO and the TDO enable is registered in a cycle where that strobe is high. Outside the shift window, TDO follows an idle policy set by a two-bit mode input. In the hold mode it keeps its last level. In either default-level mode it drives a programmed level. In the fourth mode it is released to high impedance through the separate `tdo_oe` output. The pad itself is built at the chip top.

Top module: `jsm_shift_seq`

## Requirements
- R1: After synchronous reset: `tms`=1, `tdo`=0, `tdo_oe`=0, `busy`=0, `done`=0, `vec_ready`=0.
- R2: `tms`, `tdo` and `tdo_oe` change only in the cycle after a clock edge where `tck_fall` is high.
- R3: A `start` while idle latches `pat`, `vec_len` and the word count. The next eight strobed edges drive `tms` with `pat[0]` up to `pat[7]`, in that order.
- R4: On the strobed edges that follow the `pat[7]` edge, `tdo` presents the vector bits one per edge. Bits are taken from each stream word starting at its bit 0, and words are used in arrival order. During this window `tdo_oe`=1.
- R5: While vector bits are being shifted, `tms` stays at `pat[7]`. On the edge that presents the last bit (bit `vec_len`-1), `tms` takes `pat[8]`.
- R6: `done` is high for exactly the one cycle after the last-bit edge, and `busy` is low from that cycle on.
- R7: Idle mode 2'b00 (hold): on every strobed edge outside the shift window, `tdo` keeps its level and `tdo_oe`=1.
- R8: Idle modes 2'b01 and 2'b10: on every strobed edge outside the shift window, `tdo` = `idle_level` and `tdo_oe`=1.
- R9: Idle mode 2'b11: on every strobed edge outside the shift window, `tdo_oe`=0 and `tdo` keeps its level.
- R10: The idle policy also applies on the eight pattern edges (`pat[0]`..`pat[7]`) before the shift window opens.
- R11: A `start` while `busy` is ignored. The running macro keeps its pattern, length and data.
- R12: In the shift window, a strobed edge with no vector bit buffered changes no output and consumes no bit.
- R13: `vec_ready` is high only while busy and while stream words are still owed. Exactly ceil(`vec_len`/WORD_W) words are accepted per macro.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tck_fall | input | 1 | One-cycle strobe marking a TCK falling edge |
| start | input | 1 | Launch a macro (ignored while busy) |
| pat | input | 9 | TMS pattern, bit 0 first |
| vec_len | input | LEN_W | Number of vector bits, 1 or more |
| idle_mode | input | 2 | Idle TDO policy: 00 hold, 01/10 level, 11 high impedance |
| idle_level | input | 1 | Level driven in modes 01/10 |
| vec_valid | input | 1 | Stream word valid |
| vec_data | input | WORD_W | Stream word, bit 0 sent first |
| vec_ready | output | 1 | Stream word accepted when high with `vec_valid` |
| tms | output | 1 | TMS line |
| tdo | output | 1 | TDO level |
| tdo_oe | output | 1 | TDO output enable (0 = high impedance) |
| busy | output | 1 | Macro in progress |
| done | output | 1 | One-cycle end-of-macro pulse |

## Verification
The bench builds the block with WORD_W=8 and LEN_W=16. Vectors of up to 40 bits therefore cross several word boundaries. Lengths of exactly 8 and 16 land the last bit on a word edge, a length of 9 leaves a single bit in a fresh word, and a length of 1 has the last-bit edge follow the `pat[7]` edge at once. The small word width also lets the bench count every handshake against the ceiling of length over word width. It can hold the stream back to force empty-buffer edges early in the window.

// File: rtl/jsm_pkg.sv
package jsm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_SHIFT = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    IDLE_HOLD = 2'b00,
    IDLE_LOW  = 2'b01,
    IDLE_HIGH = 2'b10,
    IDLE_HIZ  = 2'b11
  } idle_mode_t;

  localparam int unsigned PAT_BITS  = 9;
  localparam int unsigned LEAD_LAST = 7;
  localparam int unsigned SHIFT_TMS = 7;
  localparam int unsigned END_TMS   = 8;

  typedef struct packed {
    logic level;
    logic oe;
  } tdo_drive_t;

endpackage

// File: rtl/jsm_idle_tdo.sv
module jsm_idle_tdo
  import jsm_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       level,
  input  logic       cur_level,
  output tdo_drive_t drive
);

  idle_mode_t m;
  assign m = idle_mode_t'(mode);

  always_comb begin
    unique case (m)
      IDLE_HOLD: drive = '{level: cur_level, oe: 1'b1};
      IDLE_LOW,
      IDLE_HIGH: drive = '{level: level,     oe: 1'b1};
      default:   drive = '{level: cur_level, oe: 1'b0};
    endcase
  end

endmodule

// File: rtl/jsm_tms_stepper.sv
module jsm_tms_stepper
  import jsm_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                arm,
  input  logic                start,
  input  logic                tck_fall,
  input  logic [PAT_BITS-1:0] pat_in,
  input  logic [LEN_W-1:0]    len_in,
  input  logic                bit_avail,
  output phase_t              phase,
  output logic                shift_edge,
  output logic                lead_edge,
  output logic                tms_nxt,
  output logic                end_bit,
  output logic                done,
  output logic                busy
);

  localparam int unsigned STEP_W = $clog2(LEAD_LAST + 1);

  logic [PAT_BITS-1:0] pat_q;
  logic [STEP_W-1:0]   step_q;
  logic [LEN_W-1:0]    left_q;
  logic                last_bit;

  assign busy       = (phase != PH_IDLE);
  assign last_bit   = (left_q == LEN_W'(1));
  assign lead_edge  = tck_fall && (phase == PH_LEAD);
  assign shift_edge = tck_fall && (phase == PH_SHIFT) && bit_avail;
  assign end_bit    = pat_q[END_TMS];

  always_comb begin
    if (phase == PH_LEAD) tms_nxt = pat_q[step_q];
    else if (last_bit)    tms_nxt = pat_q[END_TMS];
    else                  tms_nxt = pat_q[SHIFT_TMS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      pat_q  <= '0;
      step_q <= '0;
      left_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (arm) begin
            pat_q  <= pat_in;
            step_q <= '0;
            left_q <= (len_in == '0) ? LEN_W'(1) : len_in;
            phase  <= PH_LEAD;
          end
        end
        PH_LEAD: begin
          if (tck_fall) begin
            if (step_q == STEP_W'(LEAD_LAST)) phase <= PH_SHIFT;
            else step_q <= step_q + STEP_W'(1);
          end
        end
        PH_SHIFT: begin
          if (shift_edge) begin
            left_q <= left_q - LEN_W'(1);
            if (last_bit) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R6: end pulse lasts one cycle and leaves the block idle
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R11: a start during a run leaves the latched pattern alone
  a_r11_pat_kept: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(pat_q));

endmodule

// File: rtl/jsm_vec_buffer.sv
module jsm_vec_buffer
  import jsm_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              busy,
  input  logic              vec_valid,
  input  logic [WORD_W-1:0] vec_data,
  input  logic              bit_take,
  output logic              vec_ready,
  output logic              bit_avail,
  output logic              bit_val
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam int unsigned EXT_W = LEN_W + 1;

  logic [WORD_W-1:0] hold_word, sh_word;
  logic              hold_full;
  logic [CNT_W-1:0]  sh_cnt;
  logic [LEN_W-1:0]  words_left;
  logic [EXT_W-1:0]  len_ext, word_calc;
  logic              accept, from_hold;

  assign len_ext   = (len_in == '0) ? EXT_W'(1) : EXT_W'(len_in);
  assign word_calc = (len_ext + EXT_W'(WORD_W - 1)) / EXT_W'(WORD_W);

  assign vec_ready = !hold_full && (words_left != '0);
  assign accept    = vec_valid && vec_ready;
  assign from_hold = (sh_cnt == '0);
  assign bit_avail = !from_hold || hold_full;
  assign bit_val   = from_hold ? hold_word[0] : sh_word[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_word  <= '0;
      sh_word    <= '0;
      hold_full  <= 1'b0;
      sh_cnt     <= '0;
      words_left <= '0;
    end else if (arm) begin
      hold_full  <= 1'b0;
      sh_cnt     <= '0;
      words_left <= word_calc[LEN_W-1:0];
    end else begin
      if (accept) begin
        hold_word  <= vec_data;
        hold_full  <= 1'b1;
        words_left <= words_left - LEN_W'(1);
      end else if (bit_take && from_hold) begin
        hold_full <= 1'b0;
      end
      if (bit_take) begin
        if (from_hold) begin
          sh_word <= hold_word >> 1;
          sh_cnt  <= CNT_W'(WORD_W - 1);
        end else begin
          sh_word <= sh_word >> 1;
          sh_cnt  <= sh_cnt - CNT_W'(1);
        end
      end
    end
  end

  // R13: the stream is only asked for data while a macro runs
  a_r13_ready_busy: assert property (@(posedge clk) disable iff (rst)
    vec_ready |-> busy);
  // R13: an accepted word is held until the serializer takes it
  a_r13_hold_kept: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !bit_take && !arm) |=> hold_full && $stable(hold_word));

endmodule

// File: rtl/jsm_shift_seq.sv
module jsm_shift_seq
  import jsm_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tck_fall,
  input  logic                start,
  input  logic [PAT_BITS-1:0] pat,
  input  logic [LEN_W-1:0]    vec_len,
  input  logic [1:0]          idle_mode,
  input  logic                idle_level,
  input  logic                vec_valid,
  input  logic [WORD_W-1:0]   vec_data,
  output logic                vec_ready,
  output logic                tms,
  output logic                tdo,
  output logic                tdo_oe,
  output logic                busy,
  output logic                done
);

  phase_t     phase;
  logic       arm, shift_edge, lead_edge, tms_nxt, end_bit;
  logic       bit_avail, bit_val;
  tdo_drive_t idle_drv;

  assign arm = start && !busy;

  jsm_tms_stepper #(.LEN_W(LEN_W)) i_stepper (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .start      (start),
    .tck_fall   (tck_fall),
    .pat_in     (pat),
    .len_in     (vec_len),
    .bit_avail  (bit_avail),
    .phase      (phase),
    .shift_edge (shift_edge),
    .lead_edge  (lead_edge),
    .tms_nxt    (tms_nxt),
    .end_bit    (end_bit),
    .done       (done),
    .busy       (busy)
  );

  jsm_vec_buffer #(.WORD_W(WORD_W), .LEN_W(LEN_W)) i_vec_buffer (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .len_in    (vec_len),
    .busy      (busy),
    .vec_valid (vec_valid),
    .vec_data  (vec_data),
    .bit_take  (shift_edge),
    .vec_ready (vec_ready),
    .bit_avail (bit_avail),
    .bit_val   (bit_val)
  );

  jsm_idle_tdo i_idle_tdo (
    .mode      (idle_mode),
    .level     (idle_level),
    .cur_level (tdo),
    .drive     (idle_drv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tms    <= 1'b1;
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else if (shift_edge) begin
      tms    <= tms_nxt;
      tdo    <= bit_val;
      tdo_oe <= 1'b1;
    end else if (lead_edge) begin
      tms    <= tms_nxt;
      tdo    <= idle_drv.level;
      tdo_oe <= idle_drv.oe;
    end else if (tck_fall && (phase == PH_IDLE)) begin
      tdo    <= idle_drv.level;
      tdo_oe <= idle_drv.oe;
    end
  end

  // R2: pins move only on strobed edges
  a_r2_quiet_between: assert property (@(posedge clk) disable iff (rst)
    !tck_fall |=> $stable(tms) && $stable(tdo) && $stable(tdo_oe));
  // R4: driver is on while a vector bit is presented
  a_r4_oe_in_window: assert property (@(posedge clk) disable iff (rst)
    shift_edge |=> tdo_oe);
  // R5: the closing edge puts pattern bit 8 on TMS
  a_r5_end_tms: assert property (@(posedge clk) disable iff (rst)
    done |-> (tms == end_bit));
  // R9: idle high-impedance mode releases the pin
  a_r9_hiz_idle: assert property (@(posedge clk) disable iff (rst)
    (tck_fall && !busy && idle_mode == 2'b11) |=> !tdo_oe);

endmodule

// File: tb/test_jsm_shift_seq.sv
module test_jsm_shift_seq;

  localparam int LEN_W  = 16;
  localparam int WORD_W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic tck_fall = 1'b0, start = 1'b0;
  logic [8:0] pat = '0;
  logic [LEN_W-1:0] vec_len = '0;
  logic [1:0] idle_mode = 2'b00;
  logic idle_level = 1'b0;
  logic vec_valid = 1'b0;
  logic [WORD_W-1:0] vec_data = '0;
  logic vec_ready, tms, tdo, tdo_oe, busy, done;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [WORD_W-1:0] wbuf [0:15];
  int  idx = 0, nwords = 0, hs_cnt = 0;
  bit  feed_en = 1'b1;
  logic hs = 1'b0;

  logic exp_tdo = 1'b0, exp_oe = 1'b0;
  logic [2:0] snap;
  logic snap_done, snap_busy;

  always #5 clk = ~clk;

  jsm_shift_seq #(.LEN_W(LEN_W), .WORD_W(WORD_W)) i_jsm_shift_seq (
    .clk(clk), .rst(rst), .tck_fall(tck_fall), .start(start), .pat(pat),
    .vec_len(vec_len), .idle_mode(idle_mode), .idle_level(idle_level),
    .vec_valid(vec_valid), .vec_data(vec_data), .vec_ready(vec_ready),
    .tms(tms), .tdo(tdo), .tdo_oe(tdo_oe), .busy(busy), .done(done));

  initial forever begin
    @(posedge clk);
    hs <= vec_valid && vec_ready;
  end

  initial forever begin
    @(negedge clk);
    if (hs) begin idx++; hs_cnt++; end
    vec_valid = feed_en && (idx < nwords);
    vec_data  = wbuf[(idx < 16) ? idx : 0];
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] policy(logic [1:0] m, logic lvl, logic pt);
    case (m)
      2'b00:   return {pt, 1'b1};
      2'b01,
      2'b10:   return {lvl, 1'b1};
      default: return {pt, 1'b0};
    endcase
  endfunction

  task automatic do_edge();
    @(negedge clk) tck_fall = 1'b1;
    @(negedge clk) tck_fall = 1'b0;
    snap = {tms, tdo, tdo_oe};
    snap_done = done;
    snap_busy = busy;
    repeat (3) @(negedge clk);
    chk("R2 quiet", {29'd0, tms, tdo, tdo_oe}, {29'd0, snap});
  endtask

  task automatic idle_edge(string req);
    logic [1:0] e;
    e = policy(idle_mode, idle_level, exp_tdo);
    do_edge();
    exp_tdo = e[1]; exp_oe = e[0];
    chk(req, {30'd0, snap[1:0]}, {30'd0, exp_tdo, exp_oe});
  endtask

  task automatic run_macro(logic [8:0] p, int len, logic [1:0] m,
                           logic lvl, bit stall, bit restart);
    logic vb [0:127];
    logic [1:0] e;
    int nw;
    for (int i = 0; i < 128; i++) vb[i] = 1'($urandom);
    nw = (len + WORD_W - 1) / WORD_W;
    for (int w = 0; w < 16; w++)
      for (int b = 0; b < WORD_W; b++) wbuf[w][b] = vb[w * WORD_W + b];
    @(negedge clk); #1;
    idx = 0; nwords = nw; hs_cnt = 0; feed_en = !stall;
    idle_mode = m; idle_level = lvl; pat = p; vec_len = LEN_W'(len);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R3 busy", {31'd0, busy}, 32'd1);
    for (int k = 0; k < 8; k++) begin
      e = policy(m, lvl, exp_tdo);
      do_edge();
      exp_tdo = e[1]; exp_oe = e[0];
      chk("R3 lead tms", {31'd0, snap[2]}, {31'd0, p[k]});
      chk("R10 lead tdo", {30'd0, snap[1:0]}, {30'd0, exp_tdo, exp_oe});
      if (restart && k == 3) begin
        pat = ~p; vec_len = LEN_W'(3);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
      end
    end
    if (stall) begin
      for (int s = 0; s < 3; s++) begin
        do_edge();
        chk("R12 stall", {29'd0, snap}, {29'd0, p[7], exp_tdo, exp_oe});
        chk("R12 busy", {31'd0, snap_busy}, 32'd1);
      end
      feed_en = 1'b1;
      repeat (3) @(negedge clk);
    end
    for (int j = 0; j < len; j++) begin
      do_edge();
      exp_tdo = vb[j]; exp_oe = 1'b1;
      chk("R4 bit", {30'd0, snap[1:0]}, {30'd0, vb[j], 1'b1});
      chk("R5 tms", {31'd0, snap[2]}, {31'd0, (j == len - 1) ? p[8] : p[7]});
      chk("R6 done", {31'd0, snap_done}, {31'd0, (j == len - 1)});
    end
    chk("R6 busy", {31'd0, busy}, 32'd0);
    chk("R13 words", hs_cnt, nw);
    chk("R13 ready idle", {31'd0, vec_ready}, 32'd0);
    case (m)
      2'b00:   idle_edge("R7 hold after");
      2'b11:   idle_edge("R9 hiz after");
      default: idle_edge("R8 level after");
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset", {26'd0, tms, tdo, tdo_oe, busy, done, vec_ready},
        {26'd0, 6'b100000});

    idle_mode = 2'b10; idle_level = 1'b1;
    idle_edge("R8 level high");
    idle_mode = 2'b11;
    idle_edge("R9 hiz");
    idle_mode = 2'b00;
    idle_edge("R7 hold");
    idle_mode = 2'b01; idle_level = 1'b0;
    idle_edge("R8 level low");

    run_macro(9'b1_0110_0101, 1, 2'b10, 1'b1, 0, 0);
    run_macro(9'b0_1100_1011, 8, 2'b00, 1'b0, 0, 0);
    run_macro(9'b1_0011_0110, 9, 2'b11, 1'b0, 0, 0);
    run_macro(9'b0_1010_1100, 16, 2'b01, 1'b0, 0, 0);
    run_macro(9'b1_1000_0111, 5, 2'b01, 1'b0, 1, 0);
    run_macro(9'b0_0111_1001, 12, 2'b10, 1'b1, 0, 1);
    for (int r = 0; r < 10; r++) begin
      logic [1:0] m;
      m = 2'($urandom);
      run_macro(9'($urandom), 1 + int'($urandom % 40), m, (m == 2'b10),
                ($urandom % 4) == 0, ($urandom % 3) == 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule